// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves bytes over a three-wire synchronous serial link: a transfer clock, a data output and a data input. Software-side logic writes a byte into a one-deep transmit holding register. When transmission is enabled, the byte moves into a shift register and is sent least significant bit first. Output data changes on the falling edge of the transfer clock. The bit arriving on the data input is sampled on the rising edge, so every transmitted frame also receives one frame. To receive, the host must therefore write a dummy byte.

The transfer clock comes from one of two sources. The first is an internal divider paced by a count-source enable pulse, which gives a period of 2(n+1) enable ticks for divisor n. The second is an external clock pin, which is brought into the system clock domain through a two-flop synchronizer and an edge detector. The external clock must run at no more than a quarter of the system clock rate. A received frame lands in a holding register, sets a full flag and pulses a receive interrupt. An unread byte that is overwritten raises an overrun flag. The transmit interrupt pulse can be taken either from the moment the holding register empties or from the end of the frame.

Top module: `sync_serial_xcvr`

## Requirements
- R1: With the internal clock selected, `sclk_o` has a period of 2(n+1) `tick_i` pulses, where n is `baud_div_i`, and it stays high whenever no frame is in progress.
- R2: A frame is 8 bits, sent least significant bit first. `sdo_o` changes on the falling transfer-clock edge. `sdi_i` is captured on the rising edge into the top of the receive shift register (bit 7, shifting right), so the first bit received becomes bit 0. `sdo_o` is high while idle.
- R3: A byte written while `tx_en_i` is 0 is held and not sent. `tx_empty_o` is 1 only when neither the holding register nor the shift register has pending data.
- R4: When `tx_irq_sel_i` is 0, `tx_irq_o` pulses two cycles after the write cycle, as the byte leaves the holding register. When `tx_irq_sel_i` is 1, it pulses when the frame ends, in the same cycle as `rx_irq_o`.
- R5: At the end of a frame with `rx_en_i` set, the received byte appears on `rd_data_o`, `rx_full_o` goes to 1 and `rx_irq_o` pulses. A `rd_rb_i` pulse clears `rx_full_o`. With `rx_en_i` cleared, none of these change.
- R6: When `ext_clk_sel_i` is 1, bits are shifted on the synchronized edges of `sclk_i`, and `sclk_o` stays high.
- R7: Clearing `tx_en_i` mid-frame lets the current frame finish. No further frame starts and the clock stops pulsing until the enable returns.
- R8: A frame completed while `rx_full_o` is 1 and no read is made overwrites `rd_data_o` and sets `overrun_o`. Clearing `rx_en_i` clears `overrun_o`.
- R9: After reset, `sclk_o` and `sdo_o` are 1, `tx_empty_o` is 1, and `rx_full_o`, `overrun_o`, `tx_irq_o` and `rx_irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-source enable for the internal divider |
| baud_div_i | input | 8 | Divisor n of the internal transfer clock |
| ext_clk_sel_i | input | 1 | 1 selects the external clock on `sclk_i` |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive enable |
| tx_irq_sel_i | input | 1 | Transmit interrupt source: 0 buffer empty, 1 frame done |
| wr_tb_i | input | 1 | Write strobe for the transmit holding register |
| wr_data_i | input | 8 | Byte to transmit |
| rd_rb_i | input | 1 | Read strobe for the receive holding register |
| rd_data_o | output | 8 | Last received byte |
| sclk_i | input | 1 | External transfer clock |
| sclk_o | output | 1 | Internal transfer clock, idles high |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output |
| tx_empty_o | output | 1 | No transmit data pending |
| rx_full_o | output | 1 | Received byte not yet read |
| overrun_o | output | 1 | Unread byte was overwritten |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
The assertions check several properties on every cycle:
- the transfer clock returns high and holds between ticks;
- the data line idles high outside a frame;
- a load never lands on a busy shifter;
- a receive pulse always coincides with a full buffer;
- overrun only rises on top of an unread byte and drops once reception is off;
- the empty flag never shows while a frame runs.

Only the bench scenarios can show the rest:
- the bit order and the loopback byte values;
- the measured 2(n+1) period under steady and gated ticks;
- the exact interrupt cycles for each source choice;
- the held byte surviving a disabled transmitter;
- reception driven by an external clock.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  parameter int unsigned SXC_DATA_W = 8;
  parameter int unsigned SXC_DIV_W  = 8;

  typedef enum logic {
    TXI_BUF_EMPTY  = 1'b0,
    TXI_FRAME_DONE = 1'b1
  } txi_src_e;
endpackage

// File: rtl/sxc_baud.sv
module sxc_baud #(
  parameter int unsigned DIV_W = sxc_pkg::SXC_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             fall_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             clk_q, clk_d;
  logic             wrap;

  assign wrap = run_i && tick_i && (cnt_q >= div_i);

  always_comb begin
    cnt_d = cnt_q;
    clk_d = clk_q;
    if (!run_i) begin
      cnt_d = '0;
      clk_d = 1'b1;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_d = '0;
        clk_d = ~clk_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign sclk_o = clk_q;
  assign fall_o = wrap && clk_q;
  assign rise_o = wrap && !clk_q;

  // R1: clock returns high when not running
  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> clk_q);
  // R1: level only moves on a count-source tick
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> (clk_q == $past(clk_q)));
endmodule

// File: rtl/sxc_edge.sv
module sxc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o,
  output logic rise_o
);
  logic [2:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[1:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 3'b111;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign fall_o = sync_q[2] && !sync_q[1];
  assign rise_o = !sync_q[2] && sync_q[1];
endmodule

// File: rtl/sxc_shifter.sv
module sxc_shifter #(
  parameter int unsigned DW = sxc_pkg::SXC_DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          fall_i,
  input  logic          rise_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_word_o
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, sdo_q, sdo_d;

  assign done_o    = busy_q && rise_i && (cnt_q == LAST);
  assign rx_word_o = {sdi_i, rx_q[DW-1:1]};

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    sdo_d  = sdo_q;
    if (load_i) begin
      busy_d = 1'b1;
      tx_d   = data_i;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (fall_i) begin
        sdo_d = tx_q[0];
        tx_d  = {1'b0, tx_q[DW-1:1]};
      end
      if (rise_i) begin
        rx_d = {sdi_i, rx_q[DW-1:1]};
        if (cnt_q == LAST) begin
          busy_d = 1'b0;
          sdo_d  = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sdo_q  <= 1'b1;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      sdo_q  <= sdo_d;
    end
  end

  assign sdo_o  = sdo_q;
  assign busy_o = busy_q;

  // R2: data line idles high outside a frame
  p_sdo_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> sdo_q);
  // R3: the top never loads over a running frame
  p_load_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);
  // R4: frame end releases the shifter
  p_done_ends_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
endmodule

// File: rtl/sxc_rxbuf.sv
module sxc_rxbuf #(
  parameter int unsigned DW = sxc_pkg::SXC_DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          done_i,
  input  logic [DW-1:0] word_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          ovr_o,
  output logic          irq_o
);
  logic [DW-1:0] buf_q, buf_d;
  logic          full_q, full_d, ovr_q, ovr_d, irq_q, irq_d;

  always_comb begin
    buf_d  = buf_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    irq_d  = 1'b0;
    if (done_i && en_i) begin
      buf_d  = word_i;
      full_d = 1'b1;
      irq_d  = 1'b1;
      if (full_q && !rd_i) ovr_d = 1'b1;
    end else if (rd_i) begin
      full_d = 1'b0;
    end
    if (!en_i) ovr_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      irq_q  <= irq_d;
    end
  end

  assign data_o = buf_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign irq_o  = irq_q;

  // R5: a receive pulse always comes with a full buffer
  p_irq_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> full_q);
  // R8: overrun only rises on top of an unread byte
  p_ovr_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(full_q));
  // R8: disabling reception clears overrun
  p_ovr_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ovr_q);
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
  parameter int unsigned DW    = sxc_pkg::SXC_DATA_W,
  parameter int unsigned DIV_W = sxc_pkg::SXC_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             ext_clk_sel_i,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic             tx_irq_sel_i,
  input  logic             wr_tb_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_rb_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic             sclk_i,
  output logic             sclk_o,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic             tx_empty_o,
  output logic             rx_full_o,
  output logic             overrun_o,
  output logic             tx_irq_o,
  output logic             rx_irq_o
);
  import sxc_pkg::*;

  logic [DW-1:0] tb_q, tb_d, rx_word;
  logic          tb_full_q, tb_full_d, txi_q, txi_d;
  logic          busy, done, load;
  logic          b_fall, b_rise, e_fall, e_rise, fall, rise;
  txi_src_e      txi_src;

  assign txi_src = txi_src_e'(tx_irq_sel_i);
  assign load    = tx_en_i && tb_full_q && !busy;

  always_comb begin
    tb_d      = tb_q;
    tb_full_d = tb_full_q;
    if (load) tb_full_d = 1'b0;
    if (wr_tb_i) begin
      tb_d      = wr_data_i;
      tb_full_d = 1'b1;
    end
    txi_d = (txi_src == TXI_BUF_EMPTY) ? load : done;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tb_q      <= '0;
      tb_full_q <= 1'b0;
      txi_q     <= 1'b0;
    end else begin
      tb_q      <= tb_d;
      tb_full_q <= tb_full_d;
      txi_q     <= txi_d;
    end
  end

  sxc_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy && !ext_clk_sel_i),
    .tick_i (tick_i),
    .div_i  (baud_div_i),
    .sclk_o (sclk_o),
    .fall_o (b_fall),
    .rise_o (b_rise)
  );

  sxc_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (sclk_i),
    .fall_o (e_fall),
    .rise_o (e_rise)
  );

  assign fall = ext_clk_sel_i ? e_fall : b_fall;
  assign rise = ext_clk_sel_i ? e_rise : b_rise;

  sxc_shifter #(.DW(DW)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .data_i    (tb_q),
    .fall_i    (fall),
    .rise_i    (rise),
    .sdi_i     (sdi_i),
    .sdo_o     (sdo_o),
    .busy_o    (busy),
    .done_o    (done),
    .rx_word_o (rx_word)
  );

  sxc_rxbuf #(.DW(DW)) u_rxbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en_i),
    .done_i (done),
    .word_i (rx_word),
    .rd_i   (rd_rb_i),
    .data_o (rd_data_o),
    .full_o (rx_full_o),
    .ovr_o  (overrun_o),
    .irq_o  (rx_irq_o)
  );

  assign tx_empty_o = !tb_full_q && !busy;
  assign tx_irq_o   = txi_q;

  // R3: empty status never shows while a frame runs
  p_empty_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> (!busy && sclk_o));
  // R6: internal clock pin stays high under the external source
  p_ext_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_clk_sel_i && $past(ext_clk_sel_i)) |-> sclk_o);
endmodule

// File: tb/sync_serial_xcvr_test.sv
module sync_serial_xcvr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b1;
  logic       tick_half = 1'b0;
  logic [7:0] baud_div = 8'd0;
  logic       ext_sel = 1'b0, tx_en = 1'b0, rx_en = 1'b0, irq_sel = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       sclk_in = 1'b1, sclk_out, sdo, sdi, ext_bit = 1'b1, loop = 1'b1;
  logic       tx_empty, rx_full, ovr, tx_irq, rx_irq;
  int         errors = 0, checks = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;
  assign sdi = loop ? sdo : ext_bit;

  initial forever begin
    @(negedge clk);
    tick_i <= tick_half ? ~tick_i : 1'b1;
  end

  sync_serial_xcvr uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .baud_div_i(baud_div),
    .ext_clk_sel_i(ext_sel), .tx_en_i(tx_en), .rx_en_i(rx_en),
    .tx_irq_sel_i(irq_sel), .wr_tb_i(wr), .wr_data_i(wdata), .rd_rb_i(rd),
    .rd_data_o(rdata), .sclk_i(sclk_in), .sclk_o(sclk_out), .sdi_i(sdi),
    .sdo_o(sdo), .tx_empty_o(tx_empty), .rx_full_o(rx_full),
    .overrun_o(ovr), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  // {irq source, divisor, data}
  localparam logic [16:0] VECS [6] = '{
    {1'b0, 8'd0, 8'hA5}, {1'b1, 8'd1, 8'h3C}, {1'b0, 8'd2, 8'hFF},
    {1'b1, 8'd0, 8'h00}, {1'b0, 8'd3, 8'h81}, {1'b1, 8'd5, 8'h6E}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); wr = 1'b1; wdata = b;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_byte();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 5000 && !tx_empty; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_rx(output int seen);
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (rx_irq) seen = 1;
    end
  endtask

  task automatic period(input logic [7:0] n, output int per);
    logic prev;
    int f1, c;
    per = -1; f1 = -1; c = 0; prev = 1'b1;
    baud_div = n;
    wr_byte(8'h55);
    while (c < 3000 && per < 0) begin
      @(negedge clk); c++;
      if (prev && !sclk_out) begin
        if (f1 < 0) f1 = c; else per = c - f1;
      end
      prev = sclk_out;
    end
    wait_empty();
    rd_byte();
  endtask

  initial begin
    int seen, per, tx_at, rx_at, cyc;
    logic hi;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 sclk", sclk_out, 1); chk("R9 sdo", sdo, 1);
    chk("R9 empty", tx_empty, 1);
    chk("R9 flags", {rx_full, ovr, tx_irq, rx_irq}, 0);
    rst_n = 1'b1;
    tx_en = 1'b1; rx_en = 1'b1;
    @(negedge clk);

    // table of loopback frames: R2, R4, R5
    foreach (VECS[k]) begin
      irq_sel = VECS[k][16]; baud_div = VECS[k][15:8];
      @(negedge clk); wr = 1'b1; wdata = VECS[k][7:0];
      tx_at = -1; rx_at = -1; cyc = 0;
      @(negedge clk); wr = 1'b0; cyc = 1;
      while (rx_at < 0 && cyc < 5000) begin
        @(negedge clk); cyc++;
        if (tx_irq && tx_at < 0) tx_at = cyc;
        if (rx_irq) rx_at = cyc;
      end
      chk("R4 tx irq cycle", tx_at, VECS[k][16] ? rx_at : 2);
      chk("R2 loopback byte", rdata, VECS[k][7:0]);
      chk("R5 full set", rx_full, 1);
      rd_byte();
      chk("R5 full cleared", rx_full, 0);
      chk("R3 empty after", tx_empty, 1);
    end

    // R1 period with steady and halved tick rate
    period(8'd3, per); chk("R1 period n=3", per, 8);
    period(8'd0, per); chk("R1 period n=0", per, 2);
    tick_half = 1'b1;
    period(8'd2, per); chk("R1 gated tick period", per, 12);
    tick_half = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle high", sclk_out, 1);

    // R3 held byte with transmitter disabled
    tx_en = 1'b0; baud_div = 8'd1;
    wr_byte(8'h96);
    hi = 1'b1;
    repeat (30) begin @(negedge clk); hi &= sclk_out; end
    chk("R3 held not empty", tx_empty, 0);
    chk("R3 no clock while held", hi, 1);
    tx_en = 1'b1;
    wait_rx(seen);
    chk("R3 sent after enable", rdata, 8'h96);
    rd_byte();

    // R7 disable mid-frame
    baud_div = 8'd2;
    wr_byte(8'h5A);
    repeat (10) @(negedge clk);
    wr_byte(8'hC3);
    tx_en = 1'b0;
    wait_rx(seen);
    chk("R7 frame finishes", rdata, 8'h5A);
    rd_byte();
    hi = 1'b1;
    repeat (60) begin @(negedge clk); hi &= sclk_out; end
    chk("R7 clock stopped", hi, 1);
    chk("R7 next byte held", tx_empty, 0);
    tx_en = 1'b1;
    wait_rx(seen);
    chk("R7 resumes", rdata, 8'hC3);
    rd_byte();

    // R5 reception disabled
    rx_en = 1'b0; irq_sel = 1'b1;
    wr_byte(8'h0F);
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rx_irq) seen = 1;
    end
    chk("R5 no rx irq when disabled", seen, 0);
    chk("R5 data unchanged", rdata, 8'hC3);
    chk("R5 full stays clear", rx_full, 0);
    rx_en = 1'b1;

    // R8 overrun
    wr_byte(8'h11); wait_rx(seen);
    wr_byte(8'h22); wait_rx(seen);
    @(negedge clk);
    chk("R8 overrun set", ovr, 1);
    chk("R8 overwritten", rdata, 8'h22);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 overrun cleared", ovr, 0);
    rd_byte();
    rx_en = 1'b1;

    // R6 external clock, R2 bit order
    ext_sel = 1'b1; loop = 1'b0;
    wr_byte(8'h3C);
    repeat (4) @(negedge clk);
    hi = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0;
      repeat (6) begin @(negedge clk); hi &= sclk_out; end
      chk("R2 ext sdo bit", sdo, (8'h3C >> i) & 1);
      ext_bit = (8'hA5 >> i) & 1;
      repeat (2) @(negedge clk);
      sclk_in = 1'b1;
      repeat (6) begin @(negedge clk); hi &= sclk_out; end
    end
    chk("R6 internal clock idle", hi, 1);
    chk("R6 ext rx full", rx_full, 1);
    chk("R6 ext rx byte", rdata, 8'hA5);
    chk("R6 ext done empty", tx_empty, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule